// File: doc/BRIEF.md
# Attribute Controller Register File

This block holds the host-visible registers of a VGA-style attribute controller and presents their contents to the pixel path. The host reaches all of them through one byte-wide write port. An internal phase flip-flop decides what a write means. In the index phase, a write selects a register and sets a screen-enable flag. In the data phase, the next write loads the selected register. A combinational read port always shows the register that the current index selects.

There are 21 registers: 16 palette entries, mode control, border colour, plane enable, horizontal pan and colour select. While the screen-enable flag is set, palette writes are dropped. Through the pal_write_ok output the pixel path can see whether the palette is open to the host. A one-cycle pulse on phase_clr returns the flip-flop to the index phase. This lets host software bring the port to a known phase before it starts a sequence.

All pins are plain control and data strobes. No data stream passes the block's edge, so it has no valid/ready pairs and no back-pressure: each wr_en cycle is taken in the cycle it occurs.

Top module: `attr_regfile`

## Requirements
- R1: In the index phase (phase_data=0), a write stores wr_data bits 4:0 as the register index and bit 5 as the screen-enable flag, and it moves the flip-flop to the data phase (phase_data=1).
- R2: In the data phase, a write loads the register at the current index and returns the flip-flop to the index phase. Index map: 0-15 are palette entries (entry n is palette bits 8n+7:8n), 16 is mode control, 17 is border colour, 18 is plane enable, 19 is horizontal pan and 20 is colour select.
- R3: A data write to index 0-15 changes the palette only while the screen-enable flag is clear. Otherwise the palette is unchanged. pal_write_ok equals the inverse of the flag.
- R4: A data write to index 19 keeps only bits 3:0. Reading index 19 returns zero in bits 7:4.
- R5: rd_data shows the register at the current index one cycle after that register is written. Reading never changes the phase.
- R6: A data write to an index above 20 changes no register, and rd_data is zero while such an index is selected.
- R7: blink_en follows mode-control bit 3 from the cycle after that register is written.
- R8: A phase_clr pulse puts the flip-flop in the index phase on the next cycle. Any write in the same cycle is dropped.
- R9: Reset clears every register, the index and the flag, and leaves the flip-flop in the index phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write byte |
| phase_clr | input | 1 | Forces the flip-flop to the index phase |
| rd_data | output | 8 | Register at the current index |
| phase_data | output | 1 | 1 when the next write is a data write |
| cur_index | output | 5 | Current register index |
| pal_write_ok | output | 1 | Palette open to host writes |
| palette | output | 128 | 16 palette entries, entry n at bits 8n+7:8n |
| mode_ctrl | output | 8 | Mode control register |
| border | output | 8 | Border colour register |
| plane_en | output | 8 | Plane enable register |
| h_pan | output | 4 | Horizontal pan register |
| color_sel | output | 8 | Colour select register |
| blink_en | output | 1 | Blink enable (mode bit 3) |

## Verification
Plain index/data pairs to every index separate a correct phase sequence and index decode from writes that land on the wrong register. The same pairs with bit 5 set in the index byte separate palette writes that are locked from writes to non-palette registers, which stay open. Indices above 20 and writes to the pan register check that out-of-range writes are dropped and that the pan value is narrowed. phase_clr pulses issued in the data phase, and also together with a write, check that the flip-flop returns to the index phase and that the write is dropped.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int DW       = 8;
  localparam int NPAL     = 16;
  localparam int IW       = 5;
  localparam int PAN_W    = 4;
  localparam int IDX_MODE = NPAL;
  localparam int IDX_BRDR = NPAL + 1;
  localparam int IDX_PLN  = NPAL + 2;
  localparam int IDX_PAN  = NPAL + 3;
  localparam int IDX_CSEL = NPAL + 4;
  localparam int BLINK_B  = 3;

  typedef enum logic {PH_INDEX = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/attr_seq.sv
module attr_seq
  import attr_pkg::*;
#(
  parameter int W  = DW,
  parameter int XW = IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          phase_clr,
  output phase_e        phase,
  output logic [XW-1:0] idx,
  output logic          scr_on,
  output logic          data_we
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_INDEX;
      idx    <= '0;
      scr_on <= 1'b0;
    end else if (phase_clr) begin
      phase <= PH_INDEX;
    end else if (wr_en) begin
      if (phase == PH_INDEX) begin
        idx    <= wr_data[XW-1:0];
        scr_on <= wr_data[XW];
        phase  <= PH_DATA;
      end else begin
        phase <= PH_INDEX;
      end
    end
  end

  assign data_we = wr_en && !phase_clr && (phase == PH_DATA);

  AST_CLR_TO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> phase == PH_INDEX); // R8
  AST_INDEX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !phase_clr && phase == PH_INDEX) |=> (phase == PH_DATA && idx == $past(wr_data[XW-1:0]))); // R1
  AST_DATA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !phase_clr && phase == PH_DATA) |=> (phase == PH_INDEX && $stable(idx))); // R2
endmodule

// File: rtl/attr_bank.sv
module attr_bank
  import attr_pkg::*;
#(
  parameter int W  = DW,
  parameter int NP = NPAL,
  parameter int XW = IW,
  parameter int PW = PAN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_we,
  input  logic [XW-1:0]   idx,
  input  logic [W-1:0]    wr_data,
  input  logic            scr_on,
  output logic [NP*W-1:0] pal_flat,
  output logic [W-1:0]    mode_q,
  output logic [W-1:0]    brdr_q,
  output logic [W-1:0]    pln_q,
  output logic [PW-1:0]   pan_q,
  output logic [W-1:0]    csel_q
);
  localparam int LAST = NP + 4;

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_pal
      logic [W-1:0] ent;
      always_ff @(posedge clk) begin
        if (!rst_n)
          ent <= '0;
        else if (data_we && !scr_on && idx == XW'(g))
          ent <= wr_data;
      end
      assign pal_flat[g*W +: W] = ent;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      brdr_q <= '0;
      pln_q  <= '0;
      pan_q  <= '0;
      csel_q <= '0;
    end else if (data_we) begin
      if (idx == XW'(NP))     mode_q <= wr_data;
      if (idx == XW'(NP + 1)) brdr_q <= wr_data;
      if (idx == XW'(NP + 2)) pln_q  <= wr_data;
      if (idx == XW'(NP + 3)) pan_q  <= wr_data[PW-1:0];
      if (idx == XW'(NP + 4)) csel_q <= wr_data;
    end
  end

  AST_PAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && scr_on && idx < XW'(NP)) |=> $stable(pal_flat)); // R3
  AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx > XW'(LAST)) |=> ($stable(pal_flat) && $stable(mode_q) && $stable(brdr_q)
                                     && $stable(pln_q) && $stable(pan_q) && $stable(csel_q))); // R6
endmodule

// File: rtl/attr_rdmux.sv
module attr_rdmux
  import attr_pkg::*;
#(
  parameter int W  = DW,
  parameter int NP = NPAL,
  parameter int XW = IW,
  parameter int PW = PAN_W
) (
  input  logic [XW-1:0]   idx,
  input  logic [NP*W-1:0] pal_flat,
  input  logic [W-1:0]    mode_q,
  input  logic [W-1:0]    brdr_q,
  input  logic [W-1:0]    pln_q,
  input  logic [PW-1:0]   pan_q,
  input  logic [W-1:0]    csel_q,
  output logic [W-1:0]    rd_data
);
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NP; k++)
      if (idx == XW'(k)) rd_data = pal_flat[k*W +: W];
    if (idx == XW'(NP))     rd_data = mode_q;
    if (idx == XW'(NP + 1)) rd_data = brdr_q;
    if (idx == XW'(NP + 2)) rd_data = pln_q;
    if (idx == XW'(NP + 3)) rd_data = {{(W-PW){1'b0}}, pan_q};
    if (idx == XW'(NP + 4)) rd_data = csel_q;
  end
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter int W  = DW,
  parameter int NP = NPAL,
  parameter int XW = IW,
  parameter int PW = PAN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  input  logic            phase_clr,
  output logic [W-1:0]    rd_data,
  output logic            phase_data,
  output logic [XW-1:0]   cur_index,
  output logic            pal_write_ok,
  output logic [NP*W-1:0] palette,
  output logic [W-1:0]    mode_ctrl,
  output logic [W-1:0]    border,
  output logic [W-1:0]    plane_en,
  output logic [PW-1:0]   h_pan,
  output logic [W-1:0]    color_sel,
  output logic            blink_en
);
  phase_e phase;
  logic   scr_on;
  logic   data_we;

  attr_seq #(.W(W), .XW(XW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .phase_clr(phase_clr), .phase(phase), .idx(cur_index),
    .scr_on(scr_on), .data_we(data_we)
  );

  attr_bank #(.W(W), .NP(NP), .XW(XW), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .idx(cur_index),
    .wr_data(wr_data), .scr_on(scr_on), .pal_flat(palette),
    .mode_q(mode_ctrl), .brdr_q(border), .pln_q(plane_en),
    .pan_q(h_pan), .csel_q(color_sel)
  );

  attr_rdmux #(.W(W), .NP(NP), .XW(XW), .PW(PW)) u_rd (
    .idx(cur_index), .pal_flat(palette), .mode_q(mode_ctrl),
    .brdr_q(border), .pln_q(plane_en), .pan_q(h_pan),
    .csel_q(color_sel), .rd_data(rd_data)
  );

  assign phase_data   = (phase == PH_DATA);
  assign pal_write_ok = !scr_on;
  assign blink_en     = mode_ctrl[BLINK_B];

  AST_BLINK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && cur_index == XW'(NP)) |=> blink_en == $past(wr_data[BLINK_B])); // R7
endmodule

// File: tb/attr_regfile_tb.sv
module attr_regfile_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = '0;
  logic         phase_clr = 1'b0;
  logic [7:0]   rd_data;
  logic         phase_data;
  logic [4:0]   cur_index;
  logic         pal_write_ok;
  logic [127:0] palette;
  logic [7:0]   mode_ctrl, border, plane_en, color_sel;
  logic [3:0]   h_pan;
  logic         blink_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_reg[21];
  int m_idx, m_scr, m_ph;

  always #5 clk = ~clk;

  attr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .phase_clr(phase_clr), .rd_data(rd_data), .phase_data(phase_data),
    .cur_index(cur_index), .pal_write_ok(pal_write_ok), .palette(palette),
    .mode_ctrl(mode_ctrl), .border(border), .plane_en(plane_en),
    .h_pan(h_pan), .color_sel(color_sel), .blink_en(blink_en)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 21; i++) m_reg[i] = 0;
    m_idx = 0; m_scr = 0; m_ph = 0;
  endtask

  task automatic model_edge(bit we, int d, bit clr);
    if (clr) m_ph = 0;
    else if (we) begin
      if (m_ph == 0) begin
        m_idx = d & 31; m_scr = (d >> 5) & 1; m_ph = 1;
      end else begin
        m_ph = 0;
        if (m_idx < 16) begin
          if (m_scr == 0) m_reg[m_idx] = d;
        end else if (m_idx == 19) m_reg[19] = d & 15;
        else if (m_idx <= 20) m_reg[m_idx] = d;
      end
    end
  endtask

  task automatic compare_all(string tag);
    int exp_rd;
    exp_rd = (m_idx <= 20) ? m_reg[m_idx] : 0;
    chk({tag, " R5 rd_data"}, rd_data, exp_rd);
    chk({tag, " R1 phase"}, phase_data, m_ph);
    chk({tag, " R1 index"}, cur_index, m_idx);
    chk({tag, " R3 pal_write_ok"}, pal_write_ok, 1 - m_scr);
    for (int i = 0; i < 16; i++)
      chk({tag, " R3 palette"}, palette[i*8 +: 8], m_reg[i]);
    chk({tag, " R2 mode"}, mode_ctrl, m_reg[16]);
    chk({tag, " R2 border"}, border, m_reg[17]);
    chk({tag, " R2 plane"}, plane_en, m_reg[18]);
    chk({tag, " R4 pan"}, h_pan, m_reg[19]);
    chk({tag, " R2 colsel"}, color_sel, m_reg[20]);
    chk({tag, " R7 blink"}, blink_en, (m_reg[16] >> 3) & 1);
  endtask

  task automatic step(string tag, bit we, int d, bit clr);
    @(negedge clk);
    wr_en = we; wr_data = d[7:0]; phase_clr = clr;
    @(posedge clk);
    model_edge(we, d, clr);
    #2;
    wr_en = 1'b0; phase_clr = 1'b0;
    compare_all(tag);
  endtask

  task automatic wr_pair(string tag, int ix, int d);
    step(tag, 1'b1, ix, 1'b0);
    step(tag, 1'b1, d, 1'b0);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    #2;
    compare_all({tag, " R9"});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset("reset");
    // R1 R2: plain pair to a palette entry
    wr_pair("pal3", 8'h03, 8'h2A);
    // R5: idle cycles keep the phase and the read value
    step("idle", 1'b0, 0, 1'b0);
    step("idle", 1'b0, 0, 1'b0);
    // R7: blink on then off
    wr_pair("blink_on", 8'h10, 8'h08);
    wr_pair("blink_off", 8'h10, 8'hF7);
    // R4: pan narrowing
    wr_pair("pan", 8'h13, 8'hFF);
    wr_pair("pan2", 8'h13, 8'hA5);
    // R3: locked palette, open non-palette
    wr_pair("pal_lock", 8'h25, 8'h77);
    wr_pair("lock_border", 8'h31, 8'h3C);
    wr_pair("pal_unlock", 8'h05, 8'h77);
    // R6: out-of-range indices
    wr_pair("hi15", 8'h15, 8'h99);
    wr_pair("hi1f", 8'h1F, 8'h55);
    wr_pair("hi3f", 8'h3F, 8'h11);
    // R8: clear in data phase, then clear together with a write
    step("clr_idx", 1'b1, 8'h11, 1'b0);
    step("clr", 1'b0, 0, 1'b1);
    step("clr_then", 1'b1, 8'h12, 1'b0);
    step("clr_wr", 1'b1, 8'hEE, 1'b1);
    step("after_clr_wr", 1'b1, 8'h0F, 1'b0);
    step("clr_in_index", 1'b0, 0, 1'b1);
    // R2: fill every index
    for (int i = 0; i < 21; i++) wr_pair("fill", i, (i * 37 + 5) & 255);
    // R5: read back every index without writing data
    for (int i = 0; i < 24; i++) begin
      step("rb_idx", 1'b1, i, 1'b0);
      step("rb_hold", 1'b0, 0, 1'b0);
      step("rb_clr", 1'b0, 0, 1'b1);
    end
    // R9: reset mid-run from the data phase
    step("pre_rst", 1'b1, 8'h10, 1'b0);
    do_reset("mid_reset");
    step("post_rst", 1'b0, 0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule